// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two 20-bit operands and a carry-in in a single combinational pass. It returns the 20-bit sum and a carry-out. The word is split into five contiguous groups, and their widths grow by one bit from the least significant end: 2, 3, 4, 5 and 6 bits. Each bit first forms a propagate term (a XOR b) and a generate term (a AND b).

The lowest group ripples directly on the real carry-in. Every higher group ripples twice in parallel, once assuming an incoming carry of 0 and once assuming 1. When the real carry from the group below arrives, it selects one of the two carry vectors and one of the two carry-outs. The selected vector is XORed with the propagate terms to give that group's sum bits. The selected carry-out drives the select of the next group, and the last one is the adder's carry-out.

Because the group widths grow, a later group has more time to finish its two ripples while the select carry travels up the chain of multiplexers. The group widths come from parameters (first width, growth step, group count), and the total width is derived from them.

Top module: `sqrt_csel_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i` + `c_in`) modulo 2^20 for every combination of operand values.
- R2: `c_out` equals bit 20 of the 21-bit value `a_i` + `b_i` + `c_in`.
- R3: The groups cover bits 0–1, 2–4, 5–8, 9–13 and 14–19. A carry produced at the top bit of any group (bit 1, 4, 8 or 13) enters the next group, and travels on through every higher bit that propagates.
- R4: When every bit propagates (`a_i` XOR `b_i` all ones, `a_i` AND `b_i` all zeros), `c_out` equals `c_in`. In that case `sum_o` is all ones when `c_in` is 0 and all zeros when `c_in` is 1.
- R5: A group in which both operands are zero passes no carry to the group above it, whatever the carry arriving from below. Its own sum bits then hold only that incoming carry, placed at the group's lowest bit.
- R6: The block holds no state. `sum_o` and `c_out` follow a change of `a_i`, `b_i` or `c_in` within the same clock period, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 20 | First operand |
| b_i | input | 20 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_o | output | 20 | Sum, modulo 2^20 |
| c_out | output | 1 | Carry out of bit 19 |

## Verification
Several cases are hard to reach with random operands. One is a carry born at the top bit of one group that must travel through a long propagate run spanning several higher groups. That run drives every select multiplexer down the chain with the carry-1 result. Another is the carry-in itself rippling through all 20 bits. The stimulus builds these on purpose: for each group boundary it places a generate at the group's top bit and propagates above it. It adds the all-propagate operand pairs with both carry-in values, and an all-zero group sitting above a carry-producing lower part. An exhaustive sweep of the low six bits of both operands, and a stream of pseudo-random words, cover the rest.

// File: rtl/sqcs_pkg.sv
package sqcs_pkg;

  // Width of group idx: widths grow linearly from the least significant group.
  function automatic int grp_w(input int first_w, input int step, input int idx);
    return first_w + step * idx;
  endfunction

  // Index of the lowest bit of group idx.
  function automatic int grp_lsb(input int first_w, input int step, input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) begin
      acc += grp_w(first_w, step, k);
    end
    return acc;
  endfunction

  // Total adder width for n_grp groups.
  function automatic int total_w(input int first_w, input int step, input int n_grp);
    return grp_lsb(first_w, step, n_grp);
  endfunction

endpackage

// File: rtl/sqcs_pg_setup.sv
module sqcs_pg_setup #(
  parameter int WIDTH = 20
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] prop_o,
  output logic [WIDTH-1:0] gen_o
);

  for (genvar bi = 0; bi < WIDTH; bi++) begin : g_bit
    assign prop_o[bi] = a_i[bi] ^ b_i[bi];
    assign gen_o[bi]  = a_i[bi] & b_i[bi];
  end

endmodule

// File: rtl/sqcs_ripple.sv
module sqcs_ripple #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] prop_i,
  input  logic [WIDTH-1:0] gen_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] cvec_o,   // carry into each bit of the group
  output logic             cout_o
);

  logic [WIDTH:0] chain;

  always_comb begin
    chain[0] = cin_i;
    for (int k = 0; k < WIDTH; k++) begin
      chain[k+1] = gen_i[k] | (prop_i[k] & chain[k]);
    end
  end

  assign cvec_o = chain[WIDTH-1:0];
  assign cout_o = chain[WIDTH];

  // R4: an all-propagate group passes its carry-in straight through.
  always_comb begin
    if (&prop_i) begin
      a_r4_full_prop_pass: assert (cout_o == cin_i)
        else $error("group carry-out differs from carry-in under full propagate");
    end
  end

  // R5: a group with no propagate and no generate emits no carry.
  always_comb begin
    if ((prop_i | gen_i) == '0) begin
      a_r5_kill_blocks: assert (cout_o == 1'b0)
        else $error("all-kill group emitted a carry");
    end
  end

endmodule

// File: rtl/sqcs_select_group.sv
module sqcs_select_group #(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] prop_i,
  input  logic [WIDTH-1:0] gen_i,
  input  logic             sel_i,    // real carry from the group below
  output logic [WIDTH-1:0] cvec_o,
  output logic             cout_o
);

  logic [WIDTH-1:0] cvec_lo;
  logic [WIDTH-1:0] cvec_hi;
  logic             cout_lo;
  logic             cout_hi;

  sqcs_ripple #(.WIDTH(WIDTH)) u_rip_lo (
    .prop_i (prop_i),
    .gen_i  (gen_i),
    .cin_i  (1'b0),
    .cvec_o (cvec_lo),
    .cout_o (cout_lo)
  );

  sqcs_ripple #(.WIDTH(WIDTH)) u_rip_hi (
    .prop_i (prop_i),
    .gen_i  (gen_i),
    .cin_i  (1'b1),
    .cvec_o (cvec_hi),
    .cout_o (cout_hi)
  );

  always_comb begin
    if (sel_i) begin
      cvec_o = cvec_hi;
      cout_o = cout_hi;
    end else begin
      cvec_o = cvec_lo;
      cout_o = cout_lo;
    end
  end

  // R3: the carry-1 chain must dominate the carry-0 chain bit for bit,
  // otherwise the selected vector cannot be the true carry for either case.
  always_comb begin
    a_r3_hi_dominates_lo: assert (((cvec_lo & ~cvec_hi) == '0) && !(cout_lo && !cout_hi))
      else $error("carry-0 chain exceeds carry-1 chain");
  end

endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder #(
  parameter int FIRST_W = 2,
  parameter int STEP_W  = 1,
  parameter int N_GRP   = 5
) (
  input  logic [sqcs_pkg::total_w(FIRST_W, STEP_W, N_GRP)-1:0] a_i,
  input  logic [sqcs_pkg::total_w(FIRST_W, STEP_W, N_GRP)-1:0] b_i,
  input  logic                                                 c_in,
  output logic [sqcs_pkg::total_w(FIRST_W, STEP_W, N_GRP)-1:0] sum_o,
  output logic                                                 c_out
);

  localparam int W = sqcs_pkg::total_w(FIRST_W, STEP_W, N_GRP);

  logic [W-1:0]   prop;
  logic [W-1:0]   gen;
  logic [W-1:0]   cvec;     // selected carry into every bit
  logic [N_GRP:0] gcarry;   // carry entering each group

  sqcs_pg_setup #(.WIDTH(W)) u_setup (
    .a_i    (a_i),
    .b_i    (b_i),
    .prop_o (prop),
    .gen_o  (gen)
  );

  assign gcarry[0] = c_in;

  for (genvar gi = 0; gi < N_GRP; gi++) begin : g_grp
    localparam int LSB = sqcs_pkg::grp_lsb(FIRST_W, STEP_W, gi);
    localparam int GW  = sqcs_pkg::grp_w(FIRST_W, STEP_W, gi);

    if (gi == 0) begin : g_first
      sqcs_ripple #(.WIDTH(GW)) u_rip (
        .prop_i (prop[LSB +: GW]),
        .gen_i  (gen[LSB +: GW]),
        .cin_i  (gcarry[gi]),
        .cvec_o (cvec[LSB +: GW]),
        .cout_o (gcarry[gi+1])
      );
    end else begin : g_sel
      sqcs_select_group #(.WIDTH(GW)) u_sel (
        .prop_i (prop[LSB +: GW]),
        .gen_i  (gen[LSB +: GW]),
        .sel_i  (gcarry[gi]),
        .cvec_o (cvec[LSB +: GW]),
        .cout_o (gcarry[gi+1])
      );
    end
  end

  assign sum_o = prop ^ cvec;
  assign c_out = gcarry[N_GRP];

  // R1/R2: the assembled result agrees with plain binary addition.
  always_comb begin
    a_r1_sum_matches_arith: assert ({c_out, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_in}))
      else $error("sum or carry-out disagrees with arithmetic");
  end

endmodule

// File: tb/sqrt_csel_adder_tb_top.sv
module sqrt_csel_adder_tb_top;

  localparam int W = 20;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic         cin;
  logic [W-1:0] sum;
  logic         cout;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  sqrt_csel_adder dut_i (
    .a_i   (a),
    .b_i   (b),
    .c_in  (cin),
    .sum_o (sum),
    .c_out (cout)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  task automatic check_val(input string req, input logic [W:0] got, input logic [W:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive at a falling edge, sample 1 ns later in the same period.
  task automatic apply(input string req, input logic [W-1:0] av,
                       input logic [W-1:0] bv, input logic cv);
    logic [W:0] exp;
    @(negedge clk);
    a = av; b = bv; cin = cv;
    #1;
    exp = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
    check_val(req, {cout, sum}, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int bnd[4];
    logic [W-1:0] lfsr_a;
    logic [W-1:0] lfsr_b;
    bnd[0] = 2; bnd[1] = 5; bnd[2] = 9; bnd[3] = 14;

    rst_n = 1'b0;
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_val("R1 reset-state zero", {cout, sum}, '0);
    rst_n = 1'b1;

    // R6: result settles within the period the inputs change.
    apply("R6 same-period response", 20'h12345, 20'h0ABCD, 1'b1);
    apply("R6 same-period response", 20'hFEDCB, 20'h00135, 1'b0);

    // R4: every bit propagates.
    apply("R4 full propagate cin0", ONES, '0, 1'b0);
    apply("R4 full propagate cin1", ONES, '0, 1'b1);
    apply("R4 alternating propagate cin1", 20'h55555, 20'hAAAAA, 1'b1);
    apply("R4 alternating propagate cin0", 20'hAAAAA, 20'h55555, 1'b0);

    // R3: carry generated at the top bit of each group, propagated upward.
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] top;
      logic [W-1:0] above;
      top   = 20'(1) << (bnd[k] - 1);
      above = ONES << bnd[k];
      apply("R3 boundary generate+propagate", top | above, top, 1'b0);
      apply("R3 boundary generate only", top, top, 1'b0);
      apply("R3 cin ripples to boundary", (20'(1) << bnd[k]) - 20'(1), '0, 1'b1);
    end

    // R5: zero group above a carry-producing lower part.
    for (int k = 0; k < 4; k++) begin
      int hi;
      logic [W-1:0] gmask;
      logic [W-1:0] low;
      hi    = (k == 3) ? W : bnd[k+1];
      gmask = ((20'(1) << hi) - 20'(1)) & ~((20'(1) << bnd[k]) - 20'(1));
      low   = (20'(1) << bnd[k]) - 20'(1);
      apply("R5 zero group stops carry", low | (ONES & ~gmask & ~low), 20'(1), 1'b0);
      apply("R5 zero group stops carry cin1", low, low, 1'b1);
    end

    // R2: carry out of bit 19.
    apply("R2 generate at msb", 20'h80000, 20'h80000, 1'b0);
    apply("R2 no carry out", 20'h7FFFF, 20'h00000, 1'b0);

    // R1: exhaustive low six bits of both operands, fixed upper pattern.
    for (int x = 0; x < 64; x++) begin
      for (int y = 0; y < 64; y++) begin
        for (int c = 0; c < 2; c++) begin
          apply("R1 low-bit sweep", {14'h2A5C, 6'(x)}, {14'h15A3, 6'(y)}, 1'(c));
        end
      end
    end

    // R1/R2: pseudo-random words from two LFSRs.
    lfsr_a = 20'hACE15;
    lfsr_b = 20'h3B7D9;
    for (int i = 0; i < 3000; i++) begin
      lfsr_a = {lfsr_a[18:0], lfsr_a[19] ^ lfsr_a[16]};
      lfsr_b = {lfsr_b[18:0], lfsr_b[19] ^ lfsr_b[16]};
      apply("R1 R2 pseudo-random", lfsr_a, lfsr_b, lfsr_a[3] ^ lfsr_b[7]);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule